// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Register

This block holds the 24-bit status word of a serial NOR flash and rules on every request that would change the array or the status word itself. A command decoder upstream turns the serial command stream into single-cycle strobes: set write latch, clear write latch, status write with its data word, page program, sector erase, block erase and chip erase. The block answers each array or status request one cycle later with an accept or a reject pulse. An accepted request raises the busy flag, which clears on an external done pulse or when an internal cycle counter runs out.

Status writes pass through a protection scheme. The scheme has five outcomes, set by the two protection-mode bits and the write-protect pin. The modes are free (software) protection, pin-controlled protection, a lock that holds until the next power cycle, and a permanent lock. Chip erase also depends on the block-protect field and the complement bit. An external address decoder reports whether a program or erase target falls in the protected area. That flag is honoured only while the block-protect field is nonzero.

Top module: `sfsr_guard`

## Requirements
- R1: After reset the status word is 0, busy is 0, and no accept or reject pulse is raised.
- R2: The write latch (status bit 1) is set by a set-latch strobe while the block is not busy, and cleared by a clear-latch strobe. It is also cleared in the cycle the busy period ends.
- R3: Request flags use index 0 = status write, 1 = page program, 2 = sector erase, 3 = block erase, 4 = chip erase. A request strobe produces exactly one pulse on acc_o or rej_o in the following cycle. With the write latch at 0, every request is rejected. When several requests arrive together, only the lowest index is handled.
- R4: An accepted request sets busy (status bit 0 and busy_o) from the next cycle. Busy stays set until an op_done_i pulse, or for BUSY_CYCLES cycles if no done pulse arrives.
- R5: While busy, the set-latch strobe and all requests produce no pulse and change no status bit.
- R6: A status write updates only bits 2–9, 11–14, 18 and 21–23. Bits 16, 17, 19 and 20 always read 0. Bits 0, 1, 10 and 15 are never taken from the data word.
- R7: The lock bits 11–13 can be set by a status write but never cleared by one.
- R8: In mode 00 (bit 8 = 0, bit 7 = 0), a status write is accepted whenever the write latch is 1, at either pin level.
- R9: In mode 01, a status write is rejected while wp_n_i is low and accepted while it is high.
- R10: In mode 10, every status write is rejected. A power-cycle pulse returns bits 8:7 to 00 and clears bits 0 and 1. All other bits are kept.
- R11: In mode 11, every status write is rejected, and a power-cycle pulse leaves the mode at 11.
- R12: Chip erase is accepted only when bits 6:2 are all 0 and bit 14 is 0.
- R13: Page program, sector erase and block erase are rejected when bits 6:2 are nonzero and tgt_prot_i is high. Otherwise they are accepted, given the write latch is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_i | input | 1 | Set write latch strobe |
| wrdi_i | input | 1 | Clear write latch strobe |
| wrsr_i | input | 1 | Status write request strobe |
| wrsr_data_i | input | 24 | Data word for a status write |
| pp_i | input | 1 | Page program request strobe |
| se_i | input | 1 | Sector erase request strobe |
| be_i | input | 1 | Block erase request strobe |
| ce_i | input | 1 | Chip erase request strobe |
| tgt_prot_i | input | 1 | Target lies in the protected area (from address decoder) |
| wp_n_i | input | 1 | Write-protect pin level, low = protect |
| pwr_cycle_i | input | 1 | Power-down/power-up event pulse |
| op_done_i | input | 1 | Internal operation finished pulse |
| status_o | output | 24 | Status word for reads |
| acc_o | output | 5 | Accept pulse per request index |
| rej_o | output | 5 | Reject pulse per request index |
| busy_o | output | 1 | Operation in progress |

## Verification
The checker watches several rules on every cycle. Accept and reject pulses never overlap. An accept follows a set write latch and is followed by busy. Nothing is accepted while busy. Reserved bits stay at zero. A permanent lock never leaves mode 11. No status write passes through the power-cycle lock or the pin lock. Chip erase is never accepted over a nonzero protect field. The end of busy and a power cycle always clear the low status bits. Other behaviour can only be shown by the bench's scenarios. This covers the full table of mode and pin combinations, before and after a power cycle, and the exact word stored after a masked write. It also covers the sticky lock bits, the busy timeout length and the request priority.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam int SR_W   = 24;
  localparam int N_REQ  = 5;

  // request indices
  localparam int REQ_WRSR = 0;
  localparam int REQ_PP   = 1;
  localparam int REQ_SE   = 2;
  localparam int REQ_BE   = 3;
  localparam int REQ_CE   = 4;

  // bit positions
  localparam int B_BUSY = 0;
  localparam int B_WEL  = 1;
  localparam int B_BP_L = 2;
  localparam int B_BP_H = 6;
  localparam int B_SRP0 = 7;
  localparam int B_SRP1 = 8;
  localparam int B_CMP  = 14;

  typedef enum logic [1:0] {
    PM_SOFT     = 2'b00,
    PM_PIN      = 2'b01,
    PM_LOCKDOWN = 2'b10,
    PM_OTP      = 2'b11
  } prot_mode_e;

  // bits that a status write may load
  function automatic logic [SR_W-1:0] writable_mask();
    logic [SR_W-1:0] m;
    m = '0;
    for (int b = 2; b <= 9; b++) m[b] = 1'b1;
    for (int b = 11; b <= 14; b++) m[b] = 1'b1;
    m[18] = 1'b1;
    for (int b = 21; b <= 23; b++) m[b] = 1'b1;
    return m;
  endfunction

  // lock bits that can only be set
  function automatic logic [SR_W-1:0] sticky_mask();
    logic [SR_W-1:0] m;
    m = '0;
    for (int b = 11; b <= 13; b++) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [SR_W-1:0] merge_status(input logic [SR_W-1:0] old_w,
                                                   input logic [SR_W-1:0] data_w);
    logic [SR_W-1:0] wm;
    wm = writable_mask();
    return (old_w & ~wm) | (data_w & wm) | (old_w & sticky_mask());
  endfunction

  function automatic logic status_write_ok(input prot_mode_e mode, input logic wp_n);
    case (mode)
      PM_SOFT: return 1'b1;
      PM_PIN:  return wp_n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic chip_erase_ok(input logic [4:0] bp, input logic cmp);
    return (bp == 5'd0) && !cmp;
  endfunction

  function automatic logic region_ok(input logic [4:0] bp, input logic tgt_prot);
    return !((bp != 5'd0) && tgt_prot);
  endfunction
endpackage

// File: rtl/sfsr_req_pick.sv
module sfsr_req_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  input  logic         busy,
  output logic [N-1:0] sel
);
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign sel[i] = req[i] & ~busy;
    end else begin : g_rest
      assign sel[i] = req[i] & ~(|req[i-1:0]) & ~busy;
    end
  end
endmodule

// File: rtl/sfsr_permit.sv
module sfsr_permit
  import sfsr_pkg::*;
(
  input  logic             wel,
  input  logic [4:0]       bp,
  input  logic             cmp,
  input  logic [1:0]       srp,
  input  logic             wp_n,
  input  logic             tgt_prot,
  output logic [N_REQ-1:0] permit
);
  prot_mode_e mode;
  assign mode = prot_mode_e'(srp);

  always_comb begin
    permit           = '0;
    permit[REQ_WRSR] = wel & status_write_ok(mode, wp_n);
    permit[REQ_PP]   = wel & region_ok(bp, tgt_prot);
    permit[REQ_SE]   = wel & region_ok(bp, tgt_prot);
    permit[REQ_BE]   = wel & region_ok(bp, tgt_prot);
    permit[REQ_CE]   = wel & chip_erase_ok(bp, cmp);
  end
endmodule

// File: rtl/sfsr_busy_timer.sv
module sfsr_busy_timer #(
  parameter int BUSY_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done_i,
  input  logic clr,
  output logic busy,
  output logic finish
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign finish = busy & (done_i | (cnt == LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (finish) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfsr_guard.sv
module sfsr_guard
  import sfsr_pkg::*;
#(
  parameter int BUSY_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wren_i,
  input  logic        wrdi_i,
  input  logic        wrsr_i,
  input  logic [23:0] wrsr_data_i,
  input  logic        pp_i,
  input  logic        se_i,
  input  logic        be_i,
  input  logic        ce_i,
  input  logic        tgt_prot_i,
  input  logic        wp_n_i,
  input  logic        pwr_cycle_i,
  input  logic        op_done_i,
  output logic [23:0] status_o,
  output logic [4:0]  acc_o,
  output logic [4:0]  rej_o,
  output logic        busy_o
);
  logic [SR_W-1:0]  nv_q;
  logic             wel_q;
  logic [N_REQ-1:0] acc_q, rej_q;
  logic [N_REQ-1:0] req, sel, permit, acc_d, rej_d;
  logic             busy, op_start, op_finish;
  logic [SR_W-1:0]  merged;

  assign req      = {ce_i, be_i, se_i, pp_i, wrsr_i};
  assign acc_d    = sel & permit;
  assign rej_d    = sel & ~permit;
  assign op_start = (|acc_d) & ~pwr_cycle_i;
  assign merged   = merge_status(nv_q, wrsr_data_i);

  sfsr_req_pick #(.N(N_REQ)) u_pick (
    .req  (req),
    .busy (busy),
    .sel  (sel)
  );

  sfsr_permit u_permit (
    .wel      (wel_q),
    .bp       (nv_q[B_BP_H:B_BP_L]),
    .cmp      (nv_q[B_CMP]),
    .srp      (nv_q[B_SRP1:B_SRP0]),
    .wp_n     (wp_n_i),
    .tgt_prot (tgt_prot_i),
    .permit   (permit)
  );

  sfsr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (op_start),
    .done_i (op_done_i),
    .clr    (pwr_cycle_i),
    .busy   (busy),
    .finish (op_finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q  <= '0;
      wel_q <= 1'b0;
      acc_q <= '0;
      rej_q <= '0;
    end else if (pwr_cycle_i) begin
      wel_q <= 1'b0;
      acc_q <= '0;
      rej_q <= '0;
      if (nv_q[B_SRP1:B_SRP0] == PM_LOCKDOWN) nv_q[B_SRP1:B_SRP0] <= PM_SOFT;
    end else begin
      acc_q <= acc_d;
      rej_q <= rej_d;
      if (acc_d[REQ_WRSR]) nv_q <= merged;
      if (op_finish || wrdi_i) wel_q <= 1'b0;
      else if (wren_i && !busy) wel_q <= 1'b1;
    end
  end

  assign status_o = nv_q | {{(SR_W-2){1'b0}}, wel_q, busy};
  assign acc_o    = acc_q;
  assign rej_o    = rej_q;
  assign busy_o   = busy;
endmodule

// File: rtl/sfsr_guard_chk.sv
module sfsr_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] status_o,
  input logic [4:0]  acc_o,
  input logic [4:0]  rej_o,
  input logic        wp_n_i,
  input logic        pwr_cycle_i,
  input logic        op_finish
);
  assert_one_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_o, rej_o}));

  assert_acc_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o != 5'd0) |-> $past(status_o[1]));

  assert_acc_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o != 5'd0) |-> status_o[0]);

  assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |=> (acc_o == 5'd0) && (rej_o == 5'd0));

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[20:19] == 2'b00) && (status_o[17:16] == 2'b00));

  assert_pin_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o[0] |-> !(($past(status_o[8:7]) == 2'b01) && !$past(wp_n_i)));

  assert_lockdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[8:7] == 2'b10) |=> !acc_o[0]);

  assert_pwr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle_i |=> (status_o[1:0] == 2'b00) && (status_o[8:7] != 2'b10));

  assert_otp_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[8:7] == 2'b11) |=> (status_o[8:7] == 2'b11));

  assert_ce_guard_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o[4] |-> (($past(status_o[6:2]) == 5'd0) && !$past(status_o[14])));

  assert_finish_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_finish |=> (status_o[1:0] == 2'b00));
endmodule

bind sfsr_guard sfsr_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_o    (status_o),
  .acc_o       (acc_o),
  .rej_o       (rej_o),
  .wp_n_i      (wp_n_i),
  .pwr_cycle_i (pwr_cycle_i),
  .op_finish   (op_finish)
);

// File: tb/sfsr_guard_test.sv
`timescale 1ns/1ps
module sfsr_guard_test;
  localparam int BUSY = 12;

  localparam int C_WRSR = 0, C_PP = 1, C_SE = 2, C_BE = 3, C_CE = 4,
                 C_WREN = 5, C_WRDI = 6, C_DONE = 7, C_PWR = 8;

  // {mode[1:0], wp_n, power cycle, expect accept}
  localparam logic [4:0] VEC [9] = '{
    5'b00_0_0_1, 5'b00_1_0_1, 5'b01_0_0_0, 5'b01_1_0_1, 5'b01_0_1_0,
    5'b10_1_0_0, 5'b10_1_1_1, 5'b11_1_0_0, 5'b11_1_1_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wren_i = 0, wrdi_i = 0, wrsr_i = 0, pp_i = 0, se_i = 0, be_i = 0, ce_i = 0;
  logic tgt_prot_i = 0, wp_n_i = 1, pwr_cycle_i = 0, op_done_i = 0;
  logic [23:0] wrsr_data_i = '0;
  logic [23:0] status_o;
  logic [4:0]  acc_o, rej_o;
  logic        busy_o;

  int n_run = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  sfsr_guard #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i),
    .wrsr_data_i(wrsr_data_i), .pp_i(pp_i), .se_i(se_i), .be_i(be_i), .ce_i(ce_i),
    .tgt_prot_i(tgt_prot_i), .wp_n_i(wp_n_i), .pwr_cycle_i(pwr_cycle_i),
    .op_done_i(op_done_i), .status_o(status_o), .acc_o(acc_o), .rej_o(rej_o),
    .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cmd(input int c, input logic v);
    case (c)
      C_WRSR: wrsr_i = v;
      C_PP:   pp_i = v;
      C_SE:   se_i = v;
      C_BE:   be_i = v;
      C_CE:   ce_i = v;
      C_WREN: wren_i = v;
      C_WRDI: wrdi_i = v;
      C_DONE: op_done_i = v;
      default: pwr_cycle_i = v;
    endcase
  endtask

  // strobe for one cycle; returns at the negedge after the capturing edge
  task automatic issue(input int c, input logic [23:0] d = '0);
    @(negedge clk);
    wrsr_data_i = d;
    set_cmd(c, 1'b1);
    @(negedge clk);
    set_cmd(c, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wp_n_i = 1'b1;
    tgt_prot_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00: return "R8";
      2'b01: return "R9";
      2'b10: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // table of mode / pin / power-cycle combinations
    foreach (VEC[i]) begin
      logic [1:0]  m;
      logic        pin, pwr, exp_ok;
      logic [1:0]  m_eff;
      logic [23:0] d2;
      string       tg;
      {m, pin, pwr, exp_ok} = VEC[i];
      tg = mode_tag(m);
      m_eff = (pwr && m == 2'b10) ? 2'b00 : m;
      d2 = {14'd0, m, 7'h1C};
      do_reset();
      issue(C_WREN);
      issue(C_WRSR, {14'd0, m, 7'h04});
      chk("R8", {27'd0, acc_o}, 32'h1);
      issue(C_DONE);
      wp_n_i = pin;
      if (pwr) begin
        issue(C_PWR);
        chk(tg, {8'd0, status_o}, {14'd0, m_eff, 7'h04});
      end
      issue(C_WREN);
      issue(C_WRSR, d2);
      chk(tg, {30'd0, acc_o[0], rej_o[0]}, {30'd0, exp_ok, !exp_ok});
      if (exp_ok) begin
        issue(C_DONE);
        chk(tg, {8'd0, status_o}, {8'd0, d2});
      end else begin
        chk(tg, {8'd0, status_o}, {14'd0, m_eff, 7'h06});
      end
    end

    // directed tests
    do_reset();
    @(negedge clk);
    chk("R1", {7'd0, busy_o, status_o}, 32'h0);
    chk("R1", {22'd0, acc_o, rej_o}, 32'h0);

    issue(C_WRSR, 24'h00001C);
    chk("R3", {22'd0, acc_o, rej_o}, {22'd0, 5'd0, 5'd1});
    chk("R3", {8'd0, status_o}, 32'h0);

    issue(C_WREN);
    chk("R2", {8'd0, status_o}, 32'h2);
    issue(C_WRDI);
    chk("R2", {8'd0, status_o}, 32'h0);
    issue(C_WREN);

    issue(C_WRSR, 24'hFFFE7F);
    chk("R6", {8'd0, status_o}, 32'hE47A7F);
    chk("R4", {31'd0, busy_o}, 32'h1);

    issue(C_WRSR, 24'h000000);
    chk("R5", {22'd0, acc_o, rej_o}, 32'h0);
    issue(C_CE);
    chk("R5", {22'd0, acc_o, rej_o}, 32'h0);
    issue(C_WREN);
    chk("R5", {8'd0, status_o}, 32'hE47A7F);

    issue(C_DONE);
    chk("R2", {8'd0, status_o}, 32'hE47A7C);
    chk("R4", {31'd0, busy_o}, 32'h0);

    issue(C_WREN);
    issue(C_CE);
    chk("R12", {22'd0, acc_o, rej_o}, {22'd0, 5'd0, 5'h10});

    tgt_prot_i = 1'b1;
    issue(C_PP);
    chk("R13", {22'd0, acc_o, rej_o}, {22'd0, 5'd0, 5'h02});
    tgt_prot_i = 1'b0;
    issue(C_SE);
    chk("R13", {22'd0, acc_o, rej_o}, {22'd0, 5'h04, 5'd0});
    issue(C_DONE);

    issue(C_WREN);
    issue(C_WRSR, 24'h000000);
    issue(C_DONE);
    chk("R7", {8'd0, status_o}, 32'h003800);

    issue(C_WREN);
    issue(C_WRSR, 24'h000000);
    issue(C_DONE);
    issue(C_WREN);
    issue(C_CE);
    chk("R12", {22'd0, acc_o, rej_o}, {22'd0, 5'h10, 5'd0});
    issue(C_DONE);

    issue(C_WREN);
    issue(C_WRSR, 24'h004000);
    issue(C_DONE);
    chk("R12", {8'd0, status_o}, 32'h007800);
    issue(C_WREN);
    issue(C_CE);
    chk("R12", {22'd0, acc_o, rej_o}, {22'd0, 5'd0, 5'h10});

    // protect field zero: protected-target flag has no effect; timeout path
    tgt_prot_i = 1'b1;
    issue(C_BE);
    tgt_prot_i = 1'b0;
    chk("R13", {22'd0, acc_o, rej_o}, {22'd0, 5'h08, 5'd0});
    repeat (BUSY - 1) @(negedge clk);
    chk("R4", {31'd0, busy_o}, 32'h1);
    @(negedge clk);
    chk("R4", {31'd0, busy_o}, 32'h0);
    chk("R2", {8'd0, status_o}, 32'h007800);

    // simultaneous requests: lowest index wins
    issue(C_WREN);
    @(negedge clk);
    pp_i = 1'b1;
    se_i = 1'b1;
    @(negedge clk);
    pp_i = 1'b0;
    se_i = 1'b0;
    chk("R3", {22'd0, acc_o, rej_o}, {22'd0, 5'h02, 5'd0});
    issue(C_DONE);

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule